// File: doc/BRIEF.md
# Prioritized Interrupt Vector Register

This block sits between the status flags of a multi-buffered serial controller and the host bus. It has two read-only vector registers, one for each interrupt line. Each register shows the most urgent pending source as a 5-bit code with a suspend/finish bit beside it. Transfer groups raise interrupts through "finished" and "suspended" event pulses, and a line-select bit routes each group to line 0 or line 1. Each line keeps its own priority chain. The lowest-numbered group wins.

In multi-buffer mode a host read of a line's vector register pops the entry. It clears the pending flag of the group it showed, and the register then shows the next pending group on that line. A receive overrun is the exception. It is reported ahead of the groups, it survives reads of the vector, and it goes away only through a write-1-to-clear of its flag bit or through a read of the overrun-buffer-address register. In serial-compatibility mode the register stops showing groups. It then follows the serial status flags live, and reads have no effect.

Top module: `intvec_prio`

## Requirements
- R1: Each vector register reads as 32 bits: bits 5:1 carry the code, bit 0 the suspend bit, bits 31:6 are always 0. Bus writes to either vector address leave both registers unchanged.
- R2: After reset both registers read 0 and both interrupt lines are low. Code 0 means nothing is pending.
- R3: In multi-buffer mode, group g is shown with code g+1 (codes 01h..10h). When several groups are pending on a line, the one with the lowest number is shown.
- R4: In multi-buffer mode, a read (`rd_en` with `rd_addr` = `ADDR_VEC0`/`ADDR_VEC1`) of a register that shows a group clears that group's pending flag. From the next cycle the register shows the next pending group on that line, or 0.
- R5: The suspend bit is 1 when the shown group's most recent event was a suspend pulse, and 0 when it was a finished pulse. If both pulses arrive in one cycle, suspend wins.
- R6: In serial-compatibility mode (`compat_mode`=1) the line selected by `ser_line` shows 11h for error, 13h for overrun, 12h for receive full and 14h for transmit empty. The priority order is error, then overrun, then receive full, then transmit empty. The suspend bit is 0. No other code above 10h ever appears.
- R7: `grp_line[g]` routes group g to line 0 (bit clear) or line 1 (bit set). `irq_line[l]` is high exactly when register l shows a nonzero code.
- R8: A pulse on `ovr_set` sets a sticky overrun flag. In multi-buffer mode it is shown as 13h on the `ser_line` line, ahead of all groups, and reading the vector does not clear it. Writing `wr_data` bit `OVR_BIT` (6) as 1 to `ADDR_FLAG` clears it, and so does a read of `ADDR_OVRBUF`. Other bits written to `ADDR_FLAG` leave it set.
- R9: A group event in the same cycle as a read that pops that group wins over the clear, and the group stays pending.
- R10: In serial-compatibility mode the register follows the flag inputs without any read, and reads do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| compat_mode | input | 1 | 1 = serial-compatibility mode, 0 = multi-buffer mode |
| grp_fin | input | NG | Per-group transfer-finished pulses |
| grp_susp | input | NG | Per-group transfer-suspended pulses |
| grp_line | input | NG | Per-group interrupt line select |
| ser_line | input | 1 | Interrupt line used by the serial status sources |
| err_flag | input | 1 | Serial error flag level |
| rxfull_flag | input | 1 | Receive buffer full flag level |
| txempty_flag | input | 1 | Transmit buffer empty flag level |
| ovr_set | input | 1 | Receive overrun event pulse |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | AW | Host read address |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | AW | Host write address |
| wr_data | input | 32 | Host write data |
| vec0_rdata | output | 32 | Line 0 vector register value |
| vec1_rdata | output | 32 | Line 1 vector register value |
| irq_line | output | 2 | Interrupt line levels |

## Verification
Several properties assume stable inputs across the cycle they watch. A new interrupt in multi-buffer mode is traced back to an event pulse only while the mode, `ser_line` and `grp_line` hold still, and the pop property checks that no event hits the popped group in that cycle. The bench meets these assumptions. It changes routing and mode only between scenarios, and it asserts event pulses together with reads only in the one scenario that targets the event-beats-clear rule. All stimulus changes just after a rising edge, and a scoreboard compares the queued expected register values at the falling edge.

// File: rtl/intvec_prio.sv
module intvec_prio #(
  parameter int NG          = 16,
  parameter int AW          = 8,
  parameter logic [7:0] ADDR_VEC0   = 8'h60,
  parameter logic [7:0] ADDR_VEC1   = 8'h64,
  parameter logic [7:0] ADDR_FLAG   = 8'h10,
  parameter logic [7:0] ADDR_OVRBUF = 8'h70,
  parameter int OVR_BIT     = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          compat_mode,
  input  logic [NG-1:0] grp_fin,
  input  logic [NG-1:0] grp_susp,
  input  logic [NG-1:0] grp_line,
  input  logic          ser_line,
  input  logic          err_flag,
  input  logic          rxfull_flag,
  input  logic          txempty_flag,
  input  logic          ovr_set,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  output logic [31:0]   vec0_rdata,
  output logic [31:0]   vec1_rdata,
  output logic [1:0]    irq_line
);
  localparam int IW = (NG > 1) ? $clog2(NG) : 1;
  localparam logic [4:0] C_ERR = 5'h11, C_RXF = 5'h12, C_OVR = 5'h13, C_TXE = 5'h14;

  logic [NG-1:0] pend, susp_q, clr;
  logic          ovr_q;
  logic [4:0]    code  [2];
  logic          sbit  [2];
  logic          gshow [2];
  logic [IW-1:0] gidx  [2];
  logic          rd_vec [2];

  assign rd_vec[0] = rd_en && rd_addr == ADDR_VEC0[AW-1:0];
  assign rd_vec[1] = rd_en && rd_addr == ADDR_VEC1[AW-1:0];

  for (genvar l = 0; l < 2; l++) begin : g_line
    logic [NG-1:0] mask;
    logic          found;
    logic [IW-1:0] idx;
    logic          here;

    assign mask = (l == 1) ? (pend & grp_line) : (pend & ~grp_line);
    assign here = (ser_line == l[0]);

    always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int g = NG - 1; g >= 0; g--) begin
        if (mask[g]) begin
          found = 1'b1;
          idx   = g[IW-1:0];
        end
      end
    end

    always_comb begin
      code[l]  = 5'd0;
      sbit[l]  = 1'b0;
      gshow[l] = 1'b0;
      gidx[l]  = idx;
      if (compat_mode) begin
        if (here) begin
          if (err_flag)          code[l] = C_ERR;
          else if (ovr_q)        code[l] = C_OVR;
          else if (rxfull_flag)  code[l] = C_RXF;
          else if (txempty_flag) code[l] = C_TXE;
        end
      end else if (here && ovr_q) begin
        code[l] = C_OVR;
      end else if (found) begin
        code[l]  = 5'(idx) + 5'd1;
        sbit[l]  = susp_q[idx];
        gshow[l] = 1'b1;
      end
    end
  end

  always_comb begin
    clr = '0;
    for (int l = 0; l < 2; l++)
      if (rd_vec[l] && gshow[l]) clr[gidx[l]] = 1'b1;
  end

  wire ovr_w1c  = wr_en && wr_addr == ADDR_FLAG[AW-1:0] && wr_data[OVR_BIT];
  wire ovr_bufr = rd_en && rd_addr == ADDR_OVRBUF[AW-1:0];
  wire [NG-1:0] ev = grp_fin | grp_susp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= '0;
      susp_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      pend   <= (pend & ~clr) | ev;
      susp_q <= (susp_q & ~ev) | grp_susp;
      ovr_q  <= ovr_set | (ovr_q & ~(ovr_w1c | ovr_bufr));
    end
  end

  assign vec0_rdata  = {26'd0, code[0], sbit[0]};
  assign vec1_rdata  = {26'd0, code[1], sbit[1]};
  assign irq_line[0] = |code[0];
  assign irq_line[1] = |code[1];
endmodule

// File: rtl/intvec_prio_chk.sv
module intvec_prio_chk #(
  parameter int NG = 16,
  parameter int AW = 8,
  parameter logic [7:0] ADDR_VEC0 = 8'h60,
  parameter logic [7:0] ADDR_FLAG = 8'h10,
  parameter int OVR_BIT = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          compat_mode,
  input logic [NG-1:0] grp_fin,
  input logic [NG-1:0] grp_susp,
  input logic [NG-1:0] grp_line,
  input logic          ser_line,
  input logic          err_flag,
  input logic          ovr_set,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [31:0]   wr_data,
  input logic [31:0]   vec0_rdata,
  input logic [31:0]   vec1_rdata,
  input logic [1:0]    irq_line
);
  logic [4:0] c0, c1, cs;
  logic       ev_hit0, rd0, w1c;
  assign c0  = vec0_rdata[5:1];
  assign c1  = vec1_rdata[5:1];
  assign cs  = ser_line ? c1 : c0;
  assign rd0 = rd_en && rd_addr == ADDR_VEC0[AW-1:0];
  assign w1c = wr_en && wr_addr == ADDR_FLAG[AW-1:0] && wr_data[OVR_BIT];
  assign ev_hit0 = (c0 >= 5'd1 && c0 <= 5'(NG)) ? ev_bit(c0) : 1'b0;

  function automatic logic ev_bit(input logic [4:0] c);
    logic [NG-1:0] e;
    e = (grp_fin | grp_susp) >> (c - 5'd1);
    return e[0];
  endfunction

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    vec0_rdata[31:6] == '0 && vec1_rdata[31:6] == '0); // R1

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    c0 <= 5'h14 && c1 <= 5'h14); // R6

  AST_COMPAT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    compat_mode && err_flag |-> cs == 5'h11); // R6

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!compat_mode && !$past(compat_mode) && $stable(ser_line) && $stable(grp_line) && $rose(irq_line[0]))
      |-> $past(|(grp_fin | grp_susp) || ovr_set)); // R7

  AST_POP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!compat_mode && rd0 && c0 >= 5'd1 && c0 <= 5'(NG) && !ev_hit0)
      |=> c0 != $past(c0)); // R4

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!compat_mode && !ser_line && c0 == 5'h13 && rd0 && !w1c)
      |=> (compat_mode || cs == 5'h13)); // R8
endmodule

bind intvec_prio intvec_prio_chk #(
  .NG(NG), .AW(AW), .ADDR_VEC0(ADDR_VEC0), .ADDR_FLAG(ADDR_FLAG), .OVR_BIT(OVR_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .compat_mode(compat_mode), .grp_fin(grp_fin),
  .grp_susp(grp_susp), .grp_line(grp_line), .ser_line(ser_line), .err_flag(err_flag),
  .ovr_set(ovr_set), .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .vec0_rdata(vec0_rdata), .vec1_rdata(vec1_rdata), .irq_line(irq_line)
);

// File: tb/tb_intvec_prio.sv
module tb_intvec_prio;
  localparam int NG = 16;
  localparam logic [7:0] A_V0 = 8'h60, A_V1 = 8'h64, A_FLG = 8'h10, A_OBUF = 8'h70;

  logic clk = 0, rst_n = 0;
  logic compat_mode = 0, ser_line = 0, err_flag = 0, rxfull_flag = 0, txempty_flag = 0, ovr_set = 0;
  logic [NG-1:0] grp_fin = '0, grp_susp = '0, grp_line = '0;
  logic rd_en = 0, wr_en = 0;
  logic [7:0] rd_addr = '0, wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] vec0_rdata, vec1_rdata;
  logic [1:0] irq_line;

  int tests = 0, fails = 0;
  bit done = 0;

  intvec_prio dut (.*);

  always #5 clk = ~clk;

  int          q_kind[$];
  logic [31:0] q_val[$];
  string       q_tag[$];

  always @(negedge clk) begin
    while (q_kind.size() > 0) begin
      int k; logic [31:0] e, a; string t;
      k = q_kind.pop_front(); e = q_val.pop_front(); t = q_tag.pop_front();
      case (k)
        0: a = vec0_rdata;
        1: a = vec1_rdata;
        2: a = {31'd0, irq_line[0]};
        default: a = {31'd0, irq_line[1]};
      endcase
      tests++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: kind %0d actual %08h expected %08h", t, k, a, e);
      end
    end
  end

  function automatic logic [31:0] mk(input logic [4:0] c, input logic s);
    return {26'd0, c, s};
  endfunction

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic expv(input int k, input logic [31:0] v, input string t);
    q_kind.push_back(k); q_val.push_back(v); q_tag.push_back(t);
  endtask
  task automatic ev(input int g, input logic s);
    if (s) grp_susp[g] = 1; else grp_fin[g] = 1;
    tick(); grp_fin = '0; grp_susp = '0;
  endtask
  task automatic rd(input logic [7:0] a);
    rd_en = 1; rd_addr = a; tick(); rd_en = 0;
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; tick(); wr_en = 0;
  endtask
  task automatic settle(); @(negedge clk); @(posedge clk); #1; endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    grp_line[3] = 1; grp_line[5] = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    expv(0, 0, "R2 reset vec0"); expv(1, 0, "R2 reset vec1"); expv(2, 0, "R2 irq0 low");
    settle();

    ev(4, 0);
    expv(0, mk(5'd5, 0), "R3 group4 code5"); expv(2, 1, "R7 irq0 high"); settle();
    ev(2, 1);
    expv(0, mk(5'd3, 1), "R3/R5 group2 wins, suspend"); settle();
    rd(A_V0);
    expv(0, mk(5'd5, 0), "R4 pop advances to group4"); settle();
    rd(A_V0);
    expv(0, 0, "R4 pop to empty"); expv(2, 0, "R7 irq0 low"); settle();

    grp_fin[3] = 1; grp_fin[5] = 1; tick(); grp_fin = '0;
    expv(1, mk(5'd4, 0), "R7 line1 group3"); expv(0, 0, "R7 line0 unaffected");
    expv(3, 1, "R7 irq1 high"); settle();
    wr(A_V1, 32'hFFFF_FFFF);
    expv(1, mk(5'd4, 0), "R1 write ignored"); settle();
    rd_en = 1; rd_addr = A_V1; grp_susp[3] = 1; tick(); rd_en = 0; grp_susp = '0;
    expv(1, mk(5'd4, 1), "R9 event beats clear"); settle();
    rd(A_V1);
    expv(1, mk(5'd6, 0), "R4 next group5"); settle();
    rd(A_V1);
    expv(1, 0, "R4 line1 empty"); expv(3, 0, "R7 irq1 low"); settle();

    ev(0, 0);
    ovr_set = 1; tick(); ovr_set = 0;
    expv(0, mk(5'h13, 0), "R8 overrun first"); settle();
    rd(A_V0);
    expv(0, mk(5'h13, 0), "R8 read keeps overrun"); settle();
    wr(A_FLG, 32'h0000_0001);
    expv(0, mk(5'h13, 0), "R8 other flag bit keeps overrun"); settle();
    wr(A_FLG, 32'h0000_0040);
    expv(0, mk(5'd1, 0), "R8 w1c clears overrun"); settle();
    rd(A_V0);
    expv(0, 0, "R4 group0 popped"); settle();
    ovr_set = 1; tick(); ovr_set = 0;
    rd(A_OBUF);
    expv(0, 0, "R8 buffer-address read clears overrun"); settle();

    compat_mode = 1; err_flag = 1; rxfull_flag = 1; tick();
    expv(0, mk(5'h11, 0), "R6 error first"); settle();
    err_flag = 0; tick();
    expv(0, mk(5'h12, 0), "R10 live update to rx full"); settle();
    ovr_set = 1; tick(); ovr_set = 0;
    expv(0, mk(5'h13, 0), "R6 overrun before rx full"); settle();
    rd(A_V0);
    expv(0, mk(5'h13, 0), "R10 read no effect"); settle();
    wr(A_FLG, 32'h40); rxfull_flag = 0; txempty_flag = 1; ser_line = 1; tick();
    expv(1, mk(5'h14, 0), "R6 tx empty on line1"); expv(0, 0, "R6 line0 clear"); settle();
    ev(7, 1);
    expv(1, mk(5'h14, 0), "R6 groups hidden in compat"); settle();

    settle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule